// File: doc/BRIEF.md
# SMBus Register-Access Target

This block is a target-only SMBus port that lets a host read and write a bank of 8-bit registers inside the device. It watches the open-drain clock and data lines, which arrive as plain inputs, and pulls the data line low through a single drive-enable output. It never pulls the clock line low and never starts a transfer. The fast system clock oversamples both lines, so the same block serves any bus rate from 10 kHz to 400 kHz.

Four transaction types are recognised: Write Byte, Read Byte, Send Byte and Receive Byte. Every command byte the host sends is kept in a pointer register. Write Byte stores the following data byte at that pointer. Read Byte and Receive Byte return the register the pointer selects. Send Byte only moves the pointer. On the device side the block presents a register-file port: an address, write data with a one-cycle write strobe, and a one-cycle read strobe. Read data must be valid in the same cycle as the read strobe.

Top module: `smb_reg_target`

## Requirements
- R1: The address byte is ACKed only when its upper seven bits equal `dev_addr`. Any other address is NACKed. After a NACKed address the block leaves SDA released and issues no strobes until the next start condition.
- R2: Write Byte is address with bit 0 = 0, a command byte, then a data byte. It raises `reg_we` for exactly one cycle, with `reg_addr` equal to the command byte and `reg_wdata` equal to the data byte. All three bytes are ACKed.
- R3: Read Byte is address with bit 0 = 0, a command byte, a repeated start, address with bit 0 = 1, then one byte. That byte is the register the command selected, sent most significant bit first. The host ends it with a NACK and a stop.
- R4: Send Byte is address with bit 0 = 0, then a command byte, then a stop. The command byte is ACKed and stored as the pointer. No write strobe occurs.
- R5: Receive Byte is address with bit 0 = 1 and no command byte. It returns the register at the stored pointer. The pointer persists across transactions and is updated by the command byte of any Write Byte, Read Byte or Send Byte.
- R6: A third byte after the data byte of a write transaction is NACKed and causes no write.
- R7: A stop condition at any point returns the controller to idle and releases SDA. A start condition at any point begins a new address byte.
- R8: The drive enable changes only while SCL is low. Each change comes at least `HOLD_CYC` system cycles after the falling edge of SCL.
- R9: After reset, SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Configured 7-bit target address |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 8 | Register address (the stored pointer) |
| reg_wdata | output | 8 | Write data for the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe; `reg_rdata` is captured in the same cycle |
| reg_rdata | input | 8 | Read data from the register bank |

## Verification
Each bus event reaches the controller about three system cycles after the line moves: two synchroniser stages and one edge register. The drive enable then changes `HOLD_CYC` cycles after the detected SCL fall. The bench therefore sets its own SDA a quarter bit after SCL falls and samples the line halfway through the SCL-high phase, well clear of both delays. The write strobe follows the eighth falling edge of a data byte by one cycle. The register model is therefore checked only after the stop, and a counter of write strobes shows where no write may occur. A monitor counts system cycles of SCL low and flags any drive-enable change that comes while SCL is high or too soon after the fall.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_WDATA,
        S_EXTRA,
        S_RDATA,
        S_IGNORE
    } smb_state_e;

    typedef struct packed {
        smb_state_e          state;
        logic [CNT_W-1:0]    bitcnt;
        logic                in_ack;
        logic                rw;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   tx;
        logic [BYTE_W-1:0]   ptr;
        logic [BYTE_W-1:0]   wdata;
        logic                we;
        logic                rd;
        logic                drv_want;
    } smb_ctrl_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINE = 2;   // index 0: clock line, index 1: data line

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] lvl;
    logic [NLINE-1:0] prev_d, prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar gi = 0; gi < NLINE; gi++) begin : g_line
        logic [STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-2:0], raw[gi]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end

        assign lvl[gi] = sh_q[STAGES-1];
    end

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~prev_q[0];
    assign scl_fall  = ~lvl[0] & prev_q[0];
    assign start_det = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
    assign stop_det  = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];
endmodule

// File: rtl/smb_sda_drive.sv
module smb_sda_drive #(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_fall,
    input  logic scl_lvl,
    input  logic release_now,
    input  logic want,
    output logic sda_oe
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          busy;
        logic          oe;
    } drv_t;

    drv_t d, q;

    always_comb begin
        d = q;
        if (release_now) begin
            d.oe   = 1'b0;
            d.busy = 1'b0;
            d.cnt  = '0;
        end else if (scl_fall) begin
            d.busy = 1'b1;
            d.cnt  = '0;
        end else if (q.busy) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == HW'(HOLD_CYC - 1)) begin
                d.oe   = want;
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe = q.oe;

    // R8: pulling the data line low begins only while SCL is low
    p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R8: nothing changes on the line in the cycle after a falling edge
    p_no_early_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !release_now) |=> $stable(sda_oe));
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        dev_addr,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_rd,
    output logic              drv_want
);
    smb_ctrl_t d, q;
    logic      byte_done;
    logic      addr_hit;

    assign byte_done = (q.bitcnt == CNT_W'(BYTE_W));
    assign addr_hit  = (q.shreg[BYTE_W-1:1] == dev_addr);

    always_comb begin
        d    = q;
        d.we = 1'b0;
        d.rd = 1'b0;
        if (q.rd) d.tx = reg_rdata;

        if (stop_det) begin
            d.state    = S_IDLE;
            d.bitcnt   = '0;
            d.in_ack   = 1'b0;
            d.drv_want = 1'b0;
        end else if (start_det) begin
            d.state    = S_ADDR;
            d.bitcnt   = '0;
            d.in_ack   = 1'b0;
            d.drv_want = 1'b0;
        end else if (scl_rise) begin
            if (q.state != S_IDLE && q.state != S_IGNORE && !q.in_ack && !byte_done) begin
                d.shreg  = {q.shreg[BYTE_W-2:0], sda_lvl};
                d.bitcnt = q.bitcnt + 1'b1;
            end
        end else if (scl_fall) begin
            if (!q.in_ack && byte_done) begin
                // end of the eighth bit: decide the acknowledge slot
                d.in_ack   = 1'b1;
                d.drv_want = 1'b0;
                unique case (q.state)
                    S_ADDR: begin
                        if (addr_hit) begin
                            d.drv_want = 1'b1;
                            d.rw       = q.shreg[0];
                            d.rd       = q.shreg[0];
                        end else begin
                            d.state  = S_IGNORE;
                            d.in_ack = 1'b0;
                        end
                    end
                    S_CMD: begin
                        d.ptr      = q.shreg;
                        d.drv_want = 1'b1;
                    end
                    S_WDATA: begin
                        d.we       = 1'b1;
                        d.wdata    = q.shreg;
                        d.drv_want = 1'b1;
                    end
                    default: d.drv_want = 1'b0;
                endcase
            end else if (q.in_ack) begin
                // end of the acknowledge slot: move to the next byte
                d.in_ack   = 1'b0;
                d.bitcnt   = '0;
                d.drv_want = 1'b0;
                unique case (q.state)
                    S_ADDR: begin
                        if (q.rw) begin
                            d.state    = S_RDATA;
                            d.drv_want = ~q.tx[BYTE_W-1];
                        end else begin
                            d.state = S_CMD;
                        end
                    end
                    S_CMD:   d.state = S_WDATA;
                    S_WDATA: d.state = S_EXTRA;
                    S_RDATA: d.state = S_IGNORE;
                    default: d.state = q.state;
                endcase
            end else if (q.state == S_RDATA && q.bitcnt != '0) begin
                d.drv_want = ~q.tx[3'(BYTE_W - 1) - q.bitcnt[2:0]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign reg_addr  = q.ptr;
    assign reg_wdata = q.wdata;
    assign reg_we    = q.we;
    assign reg_rd    = q.rd;
    assign drv_want  = q.drv_want;

    // R7: a stop always lands in idle
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.state == S_IDLE));

    // R7: a start always begins a fresh address byte
    p_start_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (q.state == S_ADDR && q.bitcnt == '0));

    // R2: write strobe is a single-cycle pulse
    p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R2: read and write strobes never overlap
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_rd));

    // R1: an ignored transaction neither drives nor writes
    p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IGNORE) |-> (!drv_want && !reg_we && !reg_rd));

    // R6: surplus write bytes are never acknowledged
    p_extra_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_EXTRA) |-> (!drv_want && !reg_we));
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] dev_addr,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_rd,
    input  logic [7:0] reg_rdata
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic drv_want;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (dev_addr),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rd    (reg_rd),
        .drv_want  (drv_want)
    );

    smb_sda_drive #(.HOLD_CYC(HOLD_CYC)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_fall    (scl_fall),
        .scl_lvl     (scl_lvl),
        .release_now (start_det | stop_det),
        .want        (drv_want),
        .sda_oe      (sda_oe)
    );
endmodule

// File: tb/smb_reg_target_tb.sv
module smb_reg_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;
    localparam int Q          = 40;    // system cycles per SCL half period
    localparam logic [6:0] MY_ADDR = 7'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_rd;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0] bmem [256];
    int         wr_cnt = 0;
    int         total = 0;
    int         bad = 0;
    int         hold_viol = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_reg_target #(.SYNC_STAGES(2), .HOLD_CYC(HOLD)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (MY_ADDR),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    // device-side register bank model
    assign reg_rdata = bmem[reg_addr];
    always @(posedge clk) begin
        if (reg_we) begin
            bmem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // R8 monitor: drive changes only during SCL low, after HOLD cycles
    int  low_cnt = 0;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_oe && (scl_m || low_cnt < HOLD))
                hold_viol <= hold_viol + 1;
        end
        prev_oe <= sda_oe;
        low_cnt <= scl_m ? 0 : low_cnt + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart;
        wait_cyc(Q/2); sda_m = 1'b1;
        wait_cyc(Q/2); scl_m = 1'b1;
        wait_cyc(Q);   sda_m = 1'b0;
        wait_cyc(Q);   scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        wait_cyc(Q/2); sda_m = 1'b0;
        wait_cyc(Q/2); scl_m = 1'b1;
        wait_cyc(Q);   sda_m = 1'b1;
        wait_cyc(Q);
    endtask

    task automatic put_bit(input logic b);
        wait_cyc(Q/2); sda_m = b;
        wait_cyc(Q/2); scl_m = 1'b1;
        wait_cyc(Q);   scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wait_cyc(Q/2); sda_m = 1'b1;
        wait_cyc(Q/2); scl_m = 1'b1;
        wait_cyc(Q/2); b = sda_line;
        wait_cyc(Q/2); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            get_bit(s);
            v[i] = s;
        end
        put_bit(~master_ack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] dv,
                            output logic [2:0] acks);
        bus_start;
        send_byte({a, 1'b0}, acks[2]);
        send_byte(c, acks[1]);
        send_byte(dv, acks[0]);
        bus_stop;
    endtask

    task automatic do_read(input logic [7:0] c, output logic [7:0] v, output logic [2:0] acks);
        bus_start;
        send_byte({MY_ADDR, 1'b0}, acks[2]);
        send_byte(c, acks[1]);
        bus_rstart;
        send_byte({MY_ADDR, 1'b1}, acks[0]);
        recv_byte(1'b0, v);
        bus_stop;
    endtask

    task automatic sc_reset;
        check("R9", "sda_oe after reset", sda_oe, 0);
        check("R9", "reg_we after reset", reg_we, 0);
        check("R9", "reg_rd after reset", reg_rd, 0);
    endtask

    task automatic sc_write_byte;
        logic [2:0] acks;
        int w0;
        w0 = wr_cnt;
        do_write(MY_ADDR, 8'h10, 8'hA5, acks);
        check("R1", "address ACK on match", acks[2], 1);
        check("R2", "command+data ACKs", acks[1:0], 3);
        check("R2", "one write strobe", wr_cnt - w0, 1);
        check("R2", "reg 0x10 contents", bmem[8'h10], 8'hA5);
        do_write(MY_ADDR, 8'h11, 8'h5A, acks);
        check("R2", "reg 0x11 contents", bmem[8'h11], 8'h5A);
        check("R7", "SDA released after stop", sda_oe, 0);
    endtask

    task automatic sc_read_byte;
        logic [2:0] acks;
        logic [7:0] v;
        do_read(8'h10, v, acks);
        check("R3", "read byte acks", acks, 7);
        check("R3", "read 0x10", v, 8'hA5);
        do_read(8'h11, v, acks);
        check("R3", "read 0x11", v, 8'h5A);
        do_read(8'h42, v, acks);
        check("R3", "read untouched 0x42", v, 8'h42 ^ 8'h5C);
    endtask

    task automatic sc_send_recv;
        logic a;
        logic [7:0] v;
        int w0;
        w0 = wr_cnt;
        bus_start;
        send_byte({MY_ADDR, 1'b0}, a);
        send_byte(8'h11, a);
        bus_stop;
        check("R4", "send byte command ACK", a, 1);
        check("R4", "send byte causes no write", wr_cnt - w0, 0);
        for (int k = 0; k < 2; k++) begin
            bus_start;
            send_byte({MY_ADDR, 1'b1}, a);
            recv_byte(1'b0, v);
            bus_stop;
            check("R5", "receive byte ACK", a, 1);
            check("R5", "receive byte from pointer 0x11", v, 8'h5A);
        end
        // Read Byte of 0x10 moves the shared pointer
        begin
            logic [2:0] acks;
            do_read(8'h10, v, acks);
        end
        bus_start;
        send_byte({MY_ADDR, 1'b1}, a);
        recv_byte(1'b0, v);
        bus_stop;
        check("R5", "receive after read byte uses 0x10", v, 8'hA5);
    endtask

    task automatic sc_wrong_addr;
        logic [2:0] acks;
        int w0;
        w0 = wr_cnt;
        do_write(MY_ADDR ^ 7'h01, 8'h10, 8'h00, acks);
        check("R1", "mismatched address acks", acks, 0);
        check("R1", "no write after mismatch", wr_cnt - w0, 0);
        check("R1", "reg 0x10 unchanged", bmem[8'h10], 8'hA5);
    endtask

    task automatic sc_third_byte;
        logic [3:0] acks;
        int w0;
        w0 = wr_cnt;
        bus_start;
        send_byte({MY_ADDR, 1'b0}, acks[3]);
        send_byte(8'h20, acks[2]);
        send_byte(8'h11, acks[1]);
        send_byte(8'h77, acks[0]);
        bus_stop;
        check("R6", "acks ACK,ACK,ACK,NACK", acks, 4'b1110);
        check("R6", "single write", wr_cnt - w0, 1);
        check("R6", "reg 0x20 keeps data byte", bmem[8'h20], 8'h11);
    endtask

    task automatic sc_stop_abort;
        logic a;
        logic [2:0] acks;
        logic [7:0] v;
        int w0;
        w0 = wr_cnt;
        bus_start;
        send_byte({MY_ADDR, 1'b0}, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop;
        check("R7", "aborted write makes no strobe", wr_cnt - w0, 0);
        check("R7", "SDA released after abort", sda_oe, 0);
        do_write(MY_ADDR, 8'h31, 8'hC3, acks);
        check("R7", "write after abort acks", acks, 7);
        do_read(8'h31, v, acks);
        check("R7", "read back after abort", v, 8'hC3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5C;
        wait_cyc(5);
        sc_reset;
        rst_n = 1'b1;
        wait_cyc(5);
        sc_reset;
        sc_write_byte;
        sc_read_byte;
        sc_send_recv;
        sc_wrong_addr;
        sc_third_byte;
        sc_stop_abort;
        check("R8", "drive-change timing violations", hold_viol, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule